// File: doc/BRIEF.md
# PHY Control-Register Bus Master

This block turns single read and write requests from a host into the strobe and acknowledge traffic of a PHY's 16-bit control-register port. The host presents an address, write data and a direction bit, and pulses start. The block then runs a chain of handshakes on the PHY's control word and returns a done pulse. The done pulse carries the read data for a read, and it comes with an error pulse if the PHY stopped answering.

Each step of a transaction is a full four-phase exchange on one shared 16-bit data field. The block puts the value on the field, raises one strobe, waits for acknowledge to go high, drops the strobe with the value still held, and waits for acknowledge to go low. A write uses three such steps: address capture, data capture, then the write strobe. A read uses two: address capture, then the read strobe, with the data taken from the status word while acknowledge is high. Every wait has its own poll limit. If the limit runs out, the transaction stops at once.

Top module: `phy_cr_master`

## Requirements
- R1: After reset the control word is all zeros and the done and error outputs are low.
- R2: The control word carries the data field in bits [15:0] and four strobes: capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19. The status word carries read data in [15:0] and acknowledge in bit 16.
- R3: In the address step the address sits on the data field before capture-address rises. It stays unchanged while the strobe is high and after the strobe drops, until acknowledge is seen low.
- R4: A write raises capture-address, then capture-data carrying the write data, then the write strobe. Each strobe completes a full acknowledge rise and fall. After done the control word is all zeros.
- R5: A read raises capture-address, then the read strobe alone. rdata_o shows the status data that was present while acknowledge was high, and it is valid from the done pulse on.
- R6: Each wait for an acknowledge level polls once per clock for at most TIMEOUT cycles (default 100). When a wait runs out, the transaction aborts, done and error pulse together, and the control word returns to zero. With acknowledge held low, done comes TIMEOUT+2 cycles after the cycle that accepts start.
- R7: At most one of the four strobes is high in any cycle.
- R8: A start pulse while a transaction is in progress has no effect. It produces no extra done, and its address is never written.
- R9: Done and error are single-cycle pulses, and error is never high without done.
- R10: Acknowledge passes through a two-flop synchronizer, so a strobe is released only after acknowledge has been high at least three cycles earlier. The one exception is an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken only when idle |
| write_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | PHY register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data from the last read |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle timeout pulse, issued with done |
| cr_ctrl_o | output | 20 | Control word to the PHY |
| cr_stat_i | input | 17 | Status word from the PHY |

## Verification
The checks on stable data and on strobe release assume a well-behaved PHY. Such a PHY holds acknowledge high until the strobe drops, keeps status data steady while acknowledge is high, and never raises acknowledge with no strobe pending. The bench's PHY model follows those rules with a response delay chosen per transaction. The only exceptions are two deliberate fault cases, a PHY that never answers and one whose acknowledge is stuck high. In both, the only outcome expected is an abort.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETUP, S_ASSERT, S_WAIT_HI, S_WAIT_LO
  } cr_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_DATA, PH_WR, PH_RD
  } cr_phase_e;

  typedef enum logic [1:0] {
    WM_SETUP, WM_STROBE, WM_HOLD
  } word_mode_e;
endpackage

// File: rtl/phy_cr_sync.sv
module phy_cr_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= '0;
      ff2_q <= '0;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end
  assign q_o = ff2_q;
endmodule

// File: rtl/phy_cr_timer.sv
module phy_cr_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic exp_o
);
  localparam int CNTW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(LIMIT - 1);

  logic [CNTW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (en_i && cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
  end
  // asserted on the poll that uses up the budget
  assign exp_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/phy_cr_word.sv
module phy_cr_word
  import phy_cr_pkg::*;
#(
  parameter int DW = 16
) (
  input  cr_phase_e     phase_i,
  input  word_mode_e    mode_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW+3:0] word_o
);
  logic [DW-1:0] field;
  logic [3:0]    stb;

  always_comb begin
    field = '0;
    stb   = '0;
    unique case (phase_i)
      PH_ADDR: begin
        field  = addr_i;
        stb[0] = (mode_i == WM_STROBE);
      end
      PH_DATA: begin
        field  = wdata_i;
        stb[1] = (mode_i == WM_STROBE);
      end
      PH_WR: begin
        field  = (mode_i == WM_STROBE) ? '0 : wdata_i;
        stb[2] = (mode_i == WM_STROBE);
      end
      PH_RD: begin
        field  = '0;
        stb[3] = (mode_i == WM_STROBE);
      end
      default: ;
    endcase
  end

  assign word_o = {stb, field};
endmodule

// File: rtl/phy_cr_master.sv
module phy_cr_master
  import phy_cr_pkg::*;
#(
  parameter int DW      = 16,
  parameter int TIMEOUT = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          write_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic          err_o,
  output logic [DW+3:0] cr_ctrl_o,
  input  logic [DW:0]   cr_stat_i
);
  localparam int ACK_BIT = DW;

  cr_state_e     state_q;
  cr_phase_e     phase_q;
  logic          write_q;
  logic [DW-1:0] addr_q, wdata_q, rdata_q;
  logic [DW+3:0] ctrl_q, word;
  logic          done_q, err_q;
  logic          ack_s, tmr_clr, tmr_en, tmr_exp;
  word_mode_e    mode;

  phy_cr_sync #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cr_stat_i[ACK_BIT]),
    .q_o   (ack_s)
  );

  always_comb begin
    unique case (state_q)
      S_SETUP:  mode = WM_SETUP;
      S_ASSERT: mode = WM_STROBE;
      default:  mode = WM_HOLD;
    endcase
  end

  phy_cr_word #(.DW(DW)) u_word (
    .phase_i(phase_q),
    .mode_i (mode),
    .addr_i (addr_q),
    .wdata_i(wdata_q),
    .word_o (word)
  );

  assign tmr_en  = (state_q == S_WAIT_HI) || (state_q == S_WAIT_LO);
  assign tmr_clr = (state_q == S_ASSERT) || ((state_q == S_WAIT_HI) && ack_s);

  phy_cr_timer #(.LIMIT(TIMEOUT)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .en_i  (tmr_en),
    .exp_o (tmr_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      phase_q <= PH_ADDR;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ctrl_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          write_q <= write_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          phase_q <= PH_ADDR;
          state_q <= S_SETUP;
        end
        S_SETUP: begin
          ctrl_q  <= word;
          state_q <= S_ASSERT;
        end
        S_ASSERT: begin
          ctrl_q  <= word;
          state_q <= S_WAIT_HI;
        end
        S_WAIT_HI: begin
          if (ack_s) begin
            ctrl_q  <= word;
            if (phase_q == PH_RD) rdata_q <= cr_stat_i[DW-1:0];
            state_q <= S_WAIT_LO;
          end else if (tmr_exp) begin
            ctrl_q  <= '0;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_WAIT_LO: begin
          if (!ack_s) begin
            unique case (phase_q)
              PH_ADDR: begin
                phase_q <= write_q ? PH_DATA : PH_RD;
                state_q <= S_SETUP;
              end
              PH_DATA: begin
                phase_q <= PH_WR;
                state_q <= S_SETUP;
              end
              default: begin
                ctrl_q  <= '0;
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end
            endcase
          end else if (tmr_exp) begin
            ctrl_q  <= '0;
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cr_ctrl_o = ctrl_q;
  assign rdata_o   = rdata_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/phy_cr_master_chk.sv
module phy_cr_master_chk #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          err_o,
  input logic [DW+3:0] cr_ctrl_o,
  input logic [DW:0]   cr_stat_i
);
  logic any_stb;
  assign any_stb = |cr_ctrl_o[DW+3:DW];

  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cr_ctrl_o[DW+3:DW]));

  // R9
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  idle_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cr_ctrl_o == '0));

  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_ctrl_o[DW] && $past(cr_ctrl_o[DW])) |-> $stable(cr_ctrl_o[DW-1:0]));

  // R10
  sync_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(any_stb) && !err_o) |-> $past(cr_stat_i[DW], 3));
endmodule

bind phy_cr_master phy_cr_master_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .done_o   (done_o),
  .err_o    (err_o),
  .cr_ctrl_o(cr_ctrl_o),
  .cr_stat_i(cr_stat_i)
);

// File: tb/tb_phy_cr_master.sv
module tb_phy_cr_master;
  localparam int DW = 16;
  localparam int TO = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, wr = 1'b0;
  logic [DW-1:0] addr = '0, wdata = '0, rdata;
  logic          done, err;
  logic [DW+3:0] ctrl;
  logic [DW:0]   stat;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  phy_cr_master #(.DW(DW), .TIMEOUT(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .write_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
    .err_o(err), .cr_ctrl_o(ctrl), .cr_stat_i(stat)
  );

  // PHY model
  logic          mute = 1'b0, stuck = 1'b0, log_clr = 1'b0;
  int            dly = 0;
  logic          ack_q;
  int            wcnt;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] a_lat, d_lat, rd_q;
  logic [7:0]    log_q;
  int            log_n;
  logic          want;
  assign want = |ctrl[DW+3:DW];
  assign stat = {ack_q, rd_q};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0; wcnt <= 0; a_lat <= '0; d_lat <= '0; rd_q <= '0;
      log_q <= '0; log_n <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (log_clr) begin log_q <= '0; log_n <= 0; end
      if (mute)       ack_q <= 1'b0;
      else if (stuck) ack_q <= 1'b1;
      else if (want != ack_q) begin
        if (wcnt >= dly) begin
          ack_q <= want;
          wcnt  <= 0;
          if (want) begin
            if (ctrl[DW])   begin a_lat <= ctrl[DW-1:0]; log_q <= {log_q[5:0], 2'd0}; end
            if (ctrl[DW+1]) begin d_lat <= ctrl[DW-1:0]; log_q <= {log_q[5:0], 2'd1}; end
            if (ctrl[DW+2]) begin mem[a_lat[3:0]] <= d_lat; log_q <= {log_q[5:0], 2'd2}; end
            if (ctrl[DW+3]) begin rd_q <= mem[a_lat[3:0]]; log_q <= {log_q[5:0], 2'd3}; end
            if (!log_clr) log_n <= log_n + 1;
          end
        end else wcnt <= wcnt + 1;
      end else wcnt <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int       t_cycles;
  logic     t_err;
  logic [DW-1:0] t_rdata;

  task automatic run_txn(input logic w, input logic [DW-1:0] a,
                         input logic [DW-1:0] d, input int dl);
    dly = dl;
    @(negedge clk);
    log_clr = 1'b1; wr = w; addr = a; wdata = d; start = 1'b1;
    @(negedge clk);
    log_clr = 1'b0; start = 1'b0;
    t_cycles = 0;
    t_err = 1'b0;
    while (!done && t_cycles < 2000) begin
      @(negedge clk);
      t_cycles++;
    end
    t_err = err;
    t_rdata = rdata;
  endtask

  // wr[36] addr[35:20] data[19:4] dly[3:0]
  localparam logic [36:0] VECS [8] = '{
    {1'b1, 16'h0003, 16'hA5C3, 4'd0},
    {1'b0, 16'h0003, 16'h0000, 4'd2},
    {1'b1, 16'h000C, 16'h1234, 4'd5},
    {1'b1, 16'h0000, 16'hFFFF, 4'd1},
    {1'b0, 16'h000C, 16'h0000, 4'd9},
    {1'b0, 16'h0000, 16'h0000, 4'd0},
    {1'b1, 16'h0003, 16'h0F0F, 4'd3},
    {1'b0, 16'h0003, 16'h0000, 4'd4}
  };

  logic [DW-1:0] shadow [16];

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1
    check(ctrl == '0, "R1", "ctrl in reset", ctrl, 0);
    check(!done && !err, "R1", "done/err in reset", {done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl == '0 && !done, "R1", "ctrl after reset", ctrl, 0);

    for (int v = 0; v < 8; v++) begin
      logic          vw;
      logic [DW-1:0] va, vd;
      vw = VECS[v][36]; va = VECS[v][35:20]; vd = VECS[v][19:4];
      run_txn(vw, va, vd, int'(VECS[v][3:0]));
      check(done && !t_err, "R4", "completion without error", {done, t_err}, 2'b10);
      check(a_lat == va, "R3", "captured address", a_lat, va);
      @(negedge clk);
      check(!done, "R9", "done single cycle", done, 0);
      check(ctrl == '0, "R4", "ctrl zero after txn", ctrl, 0);
      if (vw) begin
        shadow[va[3:0]] = vd;
        // R2 order codes: 0=cap addr,1=cap data,2=write
        check(log_n == 3 && log_q[5:0] == 6'b00_01_10, "R4", "write strobe order",
              {log_n[3:0], log_q}, {4'd3, 8'h06});
        check(d_lat == vd, "R2", "captured write data", d_lat, vd);
        check(mem[va[3:0]] == vd, "R4", "phy register written", mem[va[3:0]], vd);
      end else begin
        check(log_n == 2 && log_q[3:0] == 4'b00_11, "R5", "read strobe order",
              {log_n[3:0], log_q}, {4'd2, 8'h03});
        check(t_rdata == shadow[va[3:0]], "R5", "read data", t_rdata, shadow[va[3:0]]);
      end
    end

    // R8: second start while busy is dropped
    begin
      int ndone;
      dly = 6;
      @(negedge clk);
      wr = 1'b1; addr = 16'h0006; wdata = 16'hBEEF; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (3) @(negedge clk);
      wr = 1'b1; addr = 16'h0009; wdata = 16'hDEAD; start = 1'b1;
      @(negedge clk); start = 1'b0;
      ndone = 0;
      for (int c = 0; c < 300; c++) begin
        @(negedge clk);
        if (done) ndone++;
      end
      check(ndone == 1, "R8", "done count with busy start", ndone, 1);
      check(mem[9] == 16'h0000, "R8", "ignored address untouched", mem[9], 0);
      shadow[6] = 16'hBEEF;
      run_txn(1'b0, 16'h0009, 16'h0, 1);
      check(t_rdata == 16'h0000 && !t_err, "R8", "readback ignored address", t_rdata, 0);
    end

    // R6: PHY silent -> abort after TO polls
    mute = 1'b1;
    run_txn(1'b1, 16'h0002, 16'h5555, 0);
    check(done && t_err, "R6", "timeout abort", {done, t_err}, 2'b11);
    check(t_cycles == TO + 2, "R6", "timeout latency", t_cycles, TO + 2);
    check(ctrl == '0, "R6", "ctrl zero after abort", ctrl, 0);
    check(mem[2] == 16'h0000, "R6", "no write on abort", mem[2], 0);
    @(negedge clk);
    check(!done && !err, "R9", "error single cycle", {done, err}, 0);
    mute = 1'b0;
    repeat (4) @(negedge clk);

    // R6: ack stuck high -> falling wait times out
    stuck = 1'b1;
    repeat (4) @(negedge clk);
    run_txn(1'b0, 16'h0006, 16'h0, 0);
    check(done && t_err, "R6", "stuck-high abort", {done, t_err}, 2'b11);
    stuck = 1'b0;
    repeat (6) @(negedge clk);

    // R5/R10: recovery and slow PHY
    run_txn(1'b0, 16'h0006, 16'h0, 12);
    check(!t_err && t_rdata == shadow[6], "R10", "read after recovery", t_rdata, shadow[6]);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule